// File: doc/BRIEF.md
# Canonical Virtual Address Checker

This block screens 64-bit virtual addresses before they reach translation. A pointer is usable only if its upper bits are copies of a boundary bit. In narrow mode the boundary is bit 47, which gives a 256 TiB space split into a low half and a high half. In wide mode the boundary is bit 48, which gives a 49-bit space sign-extended into the 64-bit pointer. In wide mode a tag-ignore control can also set the top byte of the pointer aside: those eight bits are then left out of the check and overwritten in the result.

Each address presented with a valid strobe produces a registered result one clock later. The result carries a fault flag and a normalized effective address. A faulting address is never passed on: its effective address is driven to zero. A pipeline stage that sits ahead of the translation lookup would use the block this way.

Top module: `canon_va_check`

## Requirements
- R1: After reset, valid_o, fault_o and addr_o are all zero.
- R2: With mode_i = 0 (narrow), an address faults unless bits 63..48 all equal bit 47.
- R3: With mode_i = 1 (wide) and tag_ign_i = 0, an address faults unless bits 63..49 all equal bit 48.
- R4: With mode_i = 1 and tag_ign_i = 1, only bits 55..49 are compared with bit 48, and bits 63..56 never cause a fault.
- R5: With mode_i = 1 and tag_ign_i = 1, a non-faulting result has bits 63..56 of addr_o set to copies of bit 48 of the input, and bits 55..0 equal to the input.
- R6: A faulting result drives addr_o to zero.
- R7: A non-faulting result with the tag not ignored has addr_o equal to addr_i.
- R8: valid_o and fault_o reflect the input presented with valid_i exactly one clock edge earlier, and back-to-back inputs give back-to-back results.
- R9: A cycle with valid_i = 0 yields valid_o = 0, fault_o = 0 and addr_o = 0 one edge later.
- R10: In narrow mode tag_ign_i has no effect, and a non-zero top byte faults there under the R2 rule.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| valid_i | input | 1 | Address strobe |
| addr_i | input | 64 | Virtual address to check |
| mode_i | input | 1 | 0: 48-bit space, 1: 49-bit space |
| tag_ign_i | input | 1 | Ignore top byte (wide mode only) |
| valid_o | output | 1 | Result valid, one cycle after valid_i |
| fault_o | output | 1 | Non-canonical address |
| addr_o | output | 64 | Normalized effective address, zero on fault |

## Verification
The assertions check several rules on every cycle. They check the one-cycle delay of valid_o behind valid_i, and that a fault appears only with a valid result. They check that a fault always carries a zero address, that a narrow-mode non-canonical input always faults, and that a clean untagged result matches the input from the cycle before. Only the bench scenarios can show the exact boundary of each mode and the tag-byte rewrite to a specific value. They also show that tag_ign_i is inert in narrow mode, with the half-space edges 0x00007FFF_FFFFFFFF and 0xFFFF8000_00000000 and their off-by-one neighbours as the key points.

// File: rtl/canon_va_pkg.sv
package canon_va_pkg;
  typedef enum logic {
    VA_MODE_NARROW = 1'b0,
    VA_MODE_WIDE   = 1'b1
  } va_mode_e;
endpackage

// File: rtl/va_range_chk.sv
// Flags whether every bit of a field is identical (all ones or all zeros).
module va_range_chk #(
  parameter int W = 16
) (
  input  logic [W-1:0] field_i,
  output logic         uniform_o
);
  assign uniform_o = (&field_i) | ~(|field_i);
endmodule

// File: rtl/va_sign_fill.sv
// Rebuilds a full-width pointer by sign-extending from bit BOUND.
module va_sign_fill #(
  parameter int ADDR_W = 64,
  parameter int BOUND  = 47
) (
  input  logic [ADDR_W-1:0] addr_i,
  output logic [ADDR_W-1:0] addr_o
);
  localparam int EXT_W = ADDR_W - 1 - BOUND;
  logic [BOUND:0] low_bits;
  assign low_bits = addr_i[BOUND:0];
  assign addr_o   = {{EXT_W{low_bits[BOUND]}}, low_bits};
endmodule

// File: rtl/va_out_stage.sv
module va_out_stage #(
  parameter int ADDR_W  = 64,
  parameter bit REG_OUT = 1'b1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic              fault_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic              valid_o,
  output logic              fault_o,
  output logic [ADDR_W-1:0] addr_o
);
  if (REG_OUT) begin : g_reg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        valid_o <= 1'b0;
        fault_o <= 1'b0;
        addr_o  <= '0;
      end else begin
        valid_o <= valid_i;
        fault_o <= fault_i;
        addr_o  <= addr_i;
      end
    end
  end else begin : g_comb
    assign valid_o = valid_i;
    assign fault_o = fault_i;
    assign addr_o  = addr_i;
  end
endmodule

// File: rtl/canon_va_check.sv
module canon_va_check
  import canon_va_pkg::*;
#(
  parameter int ADDR_W    = 64,
  parameter int VA_NARROW = 48,
  parameter int VA_WIDE   = 49,
  parameter int TAG_W     = 8,
  parameter bit REG_OUT   = 1'b1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              mode_i,
  input  logic              tag_ign_i,
  output logic              valid_o,
  output logic              fault_o,
  output logic [ADDR_W-1:0] addr_o
);
  localparam int BND_N  = VA_NARROW - 1;
  localparam int BND_W  = VA_WIDE - 1;
  localparam int TAG_LO = ADDR_W - TAG_W;

  va_mode_e mode;
  assign mode = va_mode_e'(mode_i);

  logic uni_narrow, uni_wide, uni_tag;

  va_range_chk #(.W(ADDR_W - BND_N)) u_chk_narrow (
    .field_i(addr_i[ADDR_W-1:BND_N]), .uniform_o(uni_narrow));
  va_range_chk #(.W(ADDR_W - BND_W)) u_chk_wide (
    .field_i(addr_i[ADDR_W-1:BND_W]), .uniform_o(uni_wide));
  va_range_chk #(.W(TAG_LO - BND_W)) u_chk_tag (
    .field_i(addr_i[TAG_LO-1:BND_W]), .uniform_o(uni_tag));

  logic [ADDR_W-1:0] fill_narrow, fill_wide;

  va_sign_fill #(.ADDR_W(ADDR_W), .BOUND(BND_N)) u_fill_narrow (
    .addr_i(addr_i), .addr_o(fill_narrow));
  va_sign_fill #(.ADDR_W(ADDR_W), .BOUND(BND_W)) u_fill_wide (
    .addr_i(addr_i), .addr_o(fill_wide));

  // Tag ignore is honoured only in the wide space.
  logic              canon, flt_d;
  logic [ADDR_W-1:0] eff_d;

  always_comb begin
    if (mode == VA_MODE_WIDE) begin
      canon = tag_ign_i ? uni_tag : uni_wide;
      eff_d = fill_wide;
    end else begin
      canon = uni_narrow;
      eff_d = fill_narrow;
    end
    flt_d = valid_i & ~canon;
    if (!valid_i || flt_d) eff_d = '0;
  end

  va_out_stage #(.ADDR_W(ADDR_W), .REG_OUT(REG_OUT)) u_out (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .valid_i(valid_i), .fault_i(flt_d), .addr_i(eff_d),
    .valid_o(valid_o), .fault_o(fault_o), .addr_o(addr_o));

  if (REG_OUT) begin : g_sva
    p_valid_lat_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      valid_i |=> valid_o);
    p_idle_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !valid_i |=> (!valid_o && !fault_o && addr_o == '0));
    p_fault_zero_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      fault_o |-> (valid_o && addr_o == '0));
    p_narrow_fault_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (valid_i && !mode_i &&
       addr_i[ADDR_W-1:BND_N] != '0 && addr_i[ADDR_W-1:BND_N] != '1) |=> fault_o);
    p_passthru_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (valid_i && !(mode_i && tag_ign_i)) |=> (fault_o || addr_o == $past(addr_i)));
  end
endmodule

// File: tb/tb_canon_va_check.sv
module tb_canon_va_check;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        valid_i = 1'b0;
  logic [63:0] addr_i = '0;
  logic        mode_i = 1'b0;
  logic        tag_ign_i = 1'b0;
  logic        valid_o, fault_o;
  logic [63:0] addr_o;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  always #2 clk_i = ~clk_i;

  canon_va_check dut (.*);

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Independent model from the requirements.
  function automatic logic [64:0] model(input logic [63:0] a, input bit m, input bit t);
    int bnd, top;
    bit bad;
    logic [63:0] r;
    bnd = m ? 48 : 47;
    top = (m && t) ? 55 : 63;
    bad = 1'b0;
    for (int i = bnd + 1; i <= top; i++) if (a[i] != a[bnd]) bad = 1'b1;
    r = a;
    for (int i = bnd + 1; i < 64; i++) r[i] = a[bnd];
    if (bad) r = '0;
    return {bad, r};
  endfunction

  task automatic apply(input logic [63:0] a, input bit m, input bit t, input string req);
    logic [64:0] e;
    e = model(a, m, t);
    @(negedge clk_i);
    valid_i = 1'b1; addr_i = a; mode_i = m; tag_ign_i = t;
    @(negedge clk_i);
    valid_i = 1'b0;
    chk(valid_o == 1'b1, {req, " valid"}, {63'b0, valid_o}, 64'd1);
    chk(fault_o == e[64], {req, " fault"}, {63'b0, fault_o}, {63'b0, e[64]});
    chk(addr_o == e[63:0], {req, " addr"}, addr_o, e[63:0]);
  endtask

  task automatic t_reset;
    chk(valid_o == 0 && fault_o == 0 && addr_o == 0, "R1 reset", addr_o, 64'd0);
  endtask

  task automatic t_narrow;
    apply(64'h0000_7FFF_FFFF_FFFF, 0, 0, "R2 low top");
    apply(64'hFFFF_8000_0000_0000, 0, 0, "R2 high bottom");
    apply(64'h0000_8000_0000_0000, 0, 0, "R2 R6 over low");
    apply(64'hFFFF_7FFF_FFFF_FFFF, 0, 0, "R2 R6 under high");
    apply(64'h8000_0000_0000_0000, 0, 0, "R2 bit63");
    apply(64'h1234_0000_0000_0000, 0, 0, "R7 R6 noisy");
  endtask

  task automatic t_wide;
    apply(64'h0000_FFFF_FFFF_FFFF, 1, 0, "R3 low top");
    apply(64'hFFFF_0000_0000_0000, 1, 0, "R3 high bottom");
    apply(64'h0001_0000_0000_0000, 1, 0, "R3 R6 bit48 alone");
    apply(64'hFFFE_0000_0000_0000, 1, 0, "R3 R6 bit48 clear");
    apply(64'hAB00_0000_0000_0000, 1, 0, "R3 tag not ignored");
  endtask

  task automatic t_tag;
    apply(64'hAB00_FFFF_1234_5678, 1, 1, "R4 R5 tag low");
    chk(addr_o == 64'h0000_FFFF_1234_5678, "R5 fixed low", addr_o, 64'h0000_FFFF_1234_5678);
    apply(64'h5AFF_0000_0000_0010, 1, 1, "R4 R5 tag high");
    chk(addr_o == 64'hFFFF_0000_0000_0010, "R5 fixed high", addr_o, 64'hFFFF_0000_0000_0010);
    apply(64'hFF02_0000_0000_0000, 1, 1, "R4 R6 bit49");
    apply(64'h0080_0000_0000_0000, 1, 1, "R4 R6 bit55");
  endtask

  task automatic t_narrow_tag;
    apply(64'hAB00_1234_0000_0000, 0, 1, "R10 tag ignored");
    chk(fault_o == 1'b1, "R10 fault", {63'b0, fault_o}, 64'd1);
    apply(64'h0000_1234_5678_9ABC, 0, 1, "R10 clean");
    chk(addr_o == 64'h0000_1234_5678_9ABC, "R10 addr", addr_o, 64'h0000_1234_5678_9ABC);
  endtask

  task automatic t_stream;
    logic [64:0] e1, e2;
    e1 = model(64'h0000_8000_0000_0000, 0, 0);
    e2 = model(64'h0000_0000_0000_1000, 0, 0);
    @(negedge clk_i);
    valid_i = 1; mode_i = 0; tag_ign_i = 0; addr_i = 64'h0000_8000_0000_0000;
    @(negedge clk_i);
    chk(valid_o && fault_o == e1[64], "R8 first", {63'b0, fault_o}, {63'b0, e1[64]});
    addr_i = 64'h0000_0000_0000_1000;
    @(negedge clk_i);
    chk(valid_o && fault_o == e2[64] && addr_o == e2[63:0], "R8 second", addr_o, e2[63:0]);
    valid_i = 0; addr_i = 64'hFFFF_FFFF_0000_0000;
    @(negedge clk_i);
    chk(!valid_o && !fault_o && addr_o == 0, "R9 idle", addr_o, 64'd0);
    addr_i = 64'h1111_0000_0000_0000;
    @(negedge clk_i);
    chk(!valid_o && !fault_o && addr_o == 0, "R9 idle bad addr", {63'b0, fault_o}, 64'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    t_reset();
    rst_ni = 1'b1;
    @(negedge clk_i);
    t_reset();
    t_narrow();
    t_wide();
    t_tag();
    t_narrow_tag();
    t_stream();
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule